// File: doc/BRIEF.md
# Instruction Issue Scoreboard

This block decides, cycle by cycle, whether the instruction presented to it may issue. The decision rests only on scheduling bits carried in the upper part of each 128-bit instruction word. Those bits hold a stall count, a yield flag, a read-barrier index, a write-barrier index, a 6-bit wait mask and four register-reuse hints. The hardware does no dependency analysis of its own. It follows the timing that the compiler wrote into each instruction.

The block keeps a countdown timer and six dependency barriers. Issuing an instruction does three things. Its stall count loads the timer. Its barrier indices in the range 0 to 5 set the matching barriers. Its yield flag raises a yield strobe in the same cycle. An execution unit that finishes work sends a completion pulse with a barrier index, and that pulse releases the barrier. An instruction may issue only when three conditions hold: it is valid, the timer is at zero, and no barrier selected by its wait mask is armed. The reuse hints are not interpreted here. They are forwarded to the register file unchanged.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset, all six barriers are clear and the stall timer is zero. A valid instruction with any wait mask therefore issues on the first cycle after reset.
- R2: Bit positions in the instruction word:
  - reuse hints at bits 125:122
  - wait mask at 121:116
  - read-barrier index at 115:113
  - write-barrier index at 112:110
  - yield flag at bit 109
  - stall count at 108:105

  `reuse_o` always equals bits 125:122, whether or not the instruction is valid. All other bits of the word have no effect.
- R3: When an instruction issues with stall count N, the next N cycles cannot issue. Issue is possible again in the cycle after those N cycles. A count of 0 allows issue on the very next cycle.
- R4: The largest stall count is 15. A word whose bits 127:104 equal 0x003fde encodes stall 15, no yield, both barrier indices 7 and wait mask 3. When such a word is held valid, the 15 cycles after its issue do not issue, and it issues again in the 16th.
- R5: On issue, a read-barrier or write-barrier index from 0 to 5 sets `bar_armed_o` bit [index] in the next cycle. An index of 6 or 7 sets nothing.
- R6: A completion pulse (`cpl_valid` high) with `cpl_idx` from 0 to 5 clears that barrier in the next cycle. A pulse with index 6 or 7 changes no barrier.
- R7: `issue_o` is high exactly when all three hold: `instr_valid` is high, the stall timer is zero, and the AND of `bar_armed_o` with the wait mask is zero.
- R8: `yield_o` is high exactly when `issue_o` is high and bit 109 of the word is set.
- R9: When an issue arms a barrier in the same cycle that a completion pulse clears it, the barrier ends up armed.
- R10: An instruction that does not issue changes neither the barriers nor the stall timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| instr_valid | input | 1 | The instruction word is a candidate for issue |
| instr_word | input | 128 | Candidate instruction; only the scheduling bits are used |
| cpl_valid | input | 1 | Completion pulse |
| cpl_idx | input | 3 | Barrier released by the completion pulse |
| issue_o | output | 1 | The instruction issues this cycle |
| yield_o | output | 1 | Yield strobe for an instruction that issues with its yield flag set |
| reuse_o | output | 4 | Reuse hints forwarded from the instruction word |
| bar_armed_o | output | 6 | Current barrier state, one bit per barrier |

## Verification
The assertions check the following on every cycle:
- an issue never happens while a waited-on barrier is armed;
- yield appears only with an issue;
- a nonzero stall count blocks the following cycle;
- an issued barrier index sets its barrier;
- a completion that does not conflict with an arm clears its barrier;
- no barrier is set without an issue.

Some behaviours only the bench scenarios can show. These are the full length of a 15-cycle stall window, the precedence of arm over clear on the same barrier, and completion indices 6 and 7 leaving the state alone. The bench runs random traffic against a reference model that is updated every cycle, and this compares the exact issue cycles over long sequences.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int INSTR_W   = 128;
  localparam int BAR_N     = 6;
  localparam int BAR_IDX_W = 3;
  localparam int STALL_W   = 4;
  localparam int REUSE_W   = 4;

  // Field positions inside the instruction word
  localparam int REUSE_LSB = 122;
  localparam int WAIT_LSB  = 116;
  localparam int RDB_LSB   = 113;
  localparam int WRB_LSB   = 110;
  localparam int YIELD_BIT = 109;
  localparam int STALL_LSB = 105;

  typedef struct packed {
    logic [REUSE_W-1:0]   reuse;
    logic [BAR_N-1:0]     wait_mask;
    logic [BAR_IDX_W-1:0] rd_bar;
    logic [BAR_IDX_W-1:0] wr_bar;
    logic                 yield;
    logic [STALL_W-1:0]   stall;
  } sched_ctl_t;
endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sb_ctl_decode.sv
module sb_ctl_decode
  import sb_pkg::*;
#(
  parameter int WORD_W = INSTR_W
) (
  input  logic [WORD_W-1:0] instr_word,
  output sched_ctl_t        ctl_o
);
  // Bits outside the scheduling field are not interpreted here
  logic word_unused;
  assign word_unused = ^{instr_word[WORD_W-1:REUSE_LSB+REUSE_W], instr_word[STALL_LSB-1:0]};

  always_comb begin
    ctl_o.reuse     = instr_word[REUSE_LSB +: REUSE_W];
    ctl_o.wait_mask = instr_word[WAIT_LSB  +: BAR_N];
    ctl_o.rd_bar    = instr_word[RDB_LSB   +: BAR_IDX_W];
    ctl_o.wr_bar    = instr_word[WRB_LSB   +: BAR_IDX_W];
    ctl_o.yield     = instr_word[YIELD_BIT];
    ctl_o.stall     = instr_word[STALL_LSB +: STALL_W];
  end
endmodule

// File: rtl/sb_stall_timer.sv
module sb_stall_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             idle_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_en || (cnt_q != '0);
    if (load_en) cnt_d = load_val;
    else         cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/sb_barrier_bank.sv
module sb_barrier_bank #(
  parameter int NUM_BAR = 6,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_en,
  input  logic [IDX_W-1:0]   arm_a,
  input  logic [IDX_W-1:0]   arm_b,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NUM_BAR-1:0] armed_o
);
  for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
    logic hit_arm;
    logic hit_clr;
    logic upd_en;
    logic bar_d;
    logic bar_q;

    always_comb begin
      hit_arm = arm_en && ((arm_a == IDX_W'(g)) || (arm_b == IDX_W'(g)));
      hit_clr = clr_en && (clr_idx == IDX_W'(g));
      upd_en  = hit_arm || hit_clr;
      // arm takes precedence over a simultaneous clear
      bar_d   = hit_arm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bar_q <= 1'b0;
      else if (upd_en) bar_q <= bar_d;
    end

    assign armed_o[g] = bar_q;
  end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
#(
  parameter int WORD_W  = INSTR_W,
  parameter int NUM_BAR = BAR_N,
  parameter int IDX_W   = BAR_IDX_W,
  parameter int CNT_W   = STALL_W,
  parameter int HINT_W  = REUSE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [WORD_W-1:0]  instr_word,
  input  logic               cpl_valid,
  input  logic [IDX_W-1:0]   cpl_idx,
  output logic               issue_o,
  output logic               yield_o,
  output logic [HINT_W-1:0]  reuse_o,
  output logic [NUM_BAR-1:0] bar_armed_o
);
  logic         rst_sync_n;
  sched_ctl_t   ctl;
  logic         stall_idle;
  logic [NUM_BAR-1:0] armed;
  logic         wait_hit;
  logic         issue;

  sb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sb_ctl_decode #(.WORD_W(WORD_W)) u_dec (
    .instr_word (instr_word),
    .ctl_o      (ctl)
  );

  sb_stall_timer #(.CNT_W(CNT_W)) u_stall (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (issue),
    .load_val (ctl.stall),
    .idle_o   (stall_idle)
  );

  sb_barrier_bank #(.NUM_BAR(NUM_BAR), .IDX_W(IDX_W)) u_bar (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .arm_en  (issue),
    .arm_a   (ctl.rd_bar),
    .arm_b   (ctl.wr_bar),
    .clr_en  (cpl_valid),
    .clr_idx (cpl_idx),
    .armed_o (armed)
  );

  always_comb begin
    wait_hit = |(armed & ctl.wait_mask);
    issue    = instr_valid && stall_idle && !wait_hit;
  end

  assign issue_o     = issue;
  assign yield_o     = issue && ctl.yield;
  assign reuse_o     = ctl.reuse;
  assign bar_armed_o = armed;
endmodule

// File: rtl/issue_scoreboard_chk.sv
module issue_scoreboard_chk #(
  parameter int NUM_BAR = 6,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic [NUM_BAR-1:0] wait_mask,
  input logic [IDX_W-1:0]   rd_bar,
  input logic [IDX_W-1:0]   wr_bar,
  input logic               yield_bit,
  input logic [CNT_W-1:0]   stall,
  input logic               cpl_valid,
  input logic [IDX_W-1:0]   cpl_idx,
  input logic               issue_o,
  input logic               yield_o,
  input logic [NUM_BAR-1:0] bar_armed_o
);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(NUM_BAR - 1);
  localparam logic [NUM_BAR-1:0] ONE      = NUM_BAR'(1);

  // R7: issue requires a valid instruction
  a_r7_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> instr_valid);

  // R7: no issue while a waited-on barrier is armed
  a_r7_wait_clear: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> ((bar_armed_o & wait_mask) == '0));

  // R8: yield only alongside an issue with the flag set
  a_r8_yield_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    yield_o |-> (issue_o && yield_bit));

  // R3: a nonzero stall blocks the next cycle
  a_r3_stall_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && stall != '0) |=> !issue_o);

  // R5: a read-barrier index in range is armed next cycle
  a_r5_arm_read: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && rd_bar <= LAST_IDX) |=> (((bar_armed_o >> $past(rd_bar)) & ONE) != '0));

  // R5: a write-barrier index in range is armed next cycle
  a_r5_arm_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && wr_bar <= LAST_IDX) |=> (((bar_armed_o >> $past(wr_bar)) & ONE) != '0));

  // R6: a completion with no conflicting arm clears its barrier
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_idx <= LAST_IDX &&
     !(issue_o && (rd_bar == cpl_idx || wr_bar == cpl_idx)))
    |=> (((bar_armed_o >> $past(cpl_idx)) & ONE) == '0));

  // R10: no barrier becomes armed without an issue
  a_r10_no_arm_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_o |=> ((bar_armed_o & ~$past(bar_armed_o)) == '0));
endmodule

bind issue_scoreboard issue_scoreboard_chk #(
  .NUM_BAR (NUM_BAR),
  .IDX_W   (IDX_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .instr_valid (instr_valid),
  .wait_mask   (ctl.wait_mask),
  .rd_bar      (ctl.rd_bar),
  .wr_bar      (ctl.wr_bar),
  .yield_bit   (ctl.yield),
  .stall       (ctl.stall),
  .cpl_valid   (cpl_valid),
  .cpl_idx     (cpl_idx),
  .issue_o     (issue_o),
  .yield_o     (yield_o),
  .bar_armed_o (bar_armed_o)
);

// File: tb/issue_scoreboard_tb.sv
module issue_scoreboard_tb;
  localparam int CLK_P = 10;

  logic         clk;
  logic         rst_n;
  logic         instr_valid;
  logic [127:0] instr_word;
  logic         cpl_valid;
  logic [2:0]   cpl_idx;
  logic         issue_o;
  logic         yield_o;
  logic [3:0]   reuse_o;
  logic [5:0]   bar_armed_o;

  int n_chk;
  int n_err;
  int cyc;
  int m_stall;
  logic [5:0] m_armed;
  logic last_issue;

  issue_scoreboard u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .cpl_valid   (cpl_valid),
    .cpl_idx     (cpl_idx),
    .issue_o     (issue_o),
    .yield_o     (yield_o),
    .reuse_o     (reuse_o),
    .bar_armed_o (bar_armed_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_word(input logic [3:0] reuse, input logic [5:0] wmask,
                                           input logic [2:0] rd, input logic [2:0] wr,
                                           input logic y, input logic [3:0] st);
    logic [127:0] w;
    w = {$urandom, $urandom, $urandom, $urandom};
    w[125:122] = reuse;
    w[121:116] = wmask;
    w[115:113] = rd;
    w[112:110] = wr;
    w[109]     = y;
    w[108:105] = st;
    return w;
  endfunction

  function automatic logic exp_issue(input logic v, input logic [127:0] w,
                                     input int st, input logic [5:0] arm);
    return v && (st == 0) && ((arm & w[121:116]) == 6'd0);
  endfunction

  function automatic logic [5:0] next_armed(input logic [5:0] arm, input logic iss,
                                            input logic [127:0] w, input logic cv,
                                            input logic [2:0] ci);
    logic [5:0] n;
    n = arm;
    for (int i = 0; i < 6; i++) begin
      if (cv && ci == 3'(i)) n[i] = 1'b0;
      if (iss && (w[115:113] == 3'(i) || w[112:110] == 3'(i))) n[i] = 1'b1;
    end
    return n;
  endfunction

  // One cycle: drive, compare against model, advance the model
  task automatic step(input logic v, input logic [127:0] w, input logic cv, input logic [2:0] ci);
    logic e_iss;
    @(negedge clk);
    instr_valid = v;
    instr_word  = w;
    cpl_valid   = cv;
    cpl_idx     = ci;
    #1;
    e_iss = exp_issue(v, w, m_stall, m_armed);
    chk((m_stall != 0) ? "R3 issue blocked by stall" : "R7 issue", 32'(issue_o), 32'(e_iss));
    chk("R8 yield", 32'(yield_o), 32'(e_iss && w[109]));
    chk("R2 reuse", 32'(reuse_o), 32'(w[125:122]));
    chk("R5 barrier state", 32'(bar_armed_o), 32'(m_armed));
    last_issue = issue_o;
    @(posedge clk);
    m_armed = next_armed(m_armed, e_iss, w, cv, ci);
    if (e_iss)            m_stall = int'(w[108:105]);
    else if (m_stall > 0) m_stall = m_stall - 1;
  endtask

  initial begin
    logic [127:0] w;
    int blocked;
    void'($urandom(32'd2024));
    n_chk = 0; n_err = 0; cyc = 0;
    m_stall = 0; m_armed = '0; last_issue = 1'b0;
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; cpl_valid = 1'b0; cpl_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: clean state, full wait mask issues at once
    #1 chk("R1 reset barriers", 32'(bar_armed_o), 32'd0);
    step(1'b1, mk_word(4'h5, 6'h3f, 3'd7, 3'd7, 1'b0, 4'd0), 1'b0, 3'd0);
    chk("R1 first issue", 32'(last_issue), 32'd1);

    // R4: default control value, stall 15 held
    w = {$urandom, $urandom, $urandom, $urandom};
    w[127:104] = 24'h003fde;
    step(1'b1, w, 1'b0, 3'd0);
    chk("R4 default word issues", 32'(last_issue), 32'd1);
    blocked = 0;
    for (int k = 0; k < 20; k++) begin
      step(1'b1, w, 1'b0, 3'd0);
      if (last_issue) break;
      blocked++;
    end
    chk("R4 stall 15 window", 32'(blocked), 32'd15);
    repeat (15) step(1'b0, w, 1'b0, 3'd0);

    // R9: arm and clear of barrier 2 in one cycle
    step(1'b1, mk_word(4'h0, 6'h00, 3'd2, 3'd7, 1'b1, 4'd0), 1'b1, 3'd2);
    chk("R8 yield directed", 32'(last_issue), 32'd1);
    step(1'b0, '0, 1'b0, 3'd0);
    chk("R9 arm wins", 32'(bar_armed_o[2]), 32'd1);
    // R6: index 7 completion ignored, index 2 clears
    step(1'b0, '0, 1'b1, 3'd7);
    step(1'b0, '0, 1'b0, 3'd0);
    chk("R6 index 7 ignored", 32'(bar_armed_o), 32'h04);
    // R7: waiting on barrier 2 blocks
    step(1'b1, mk_word(4'h0, 6'h04, 3'd7, 3'd7, 1'b0, 4'd0), 1'b0, 3'd0);
    chk("R7 wait blocks", 32'(last_issue), 32'd0);
    step(1'b0, '0, 1'b1, 3'd2);
    step(1'b0, '0, 1'b0, 3'd0);
    chk("R6 clear", 32'(bar_armed_o), 32'h00);

    // R10: blocked instruction leaves barriers alone; R5 write index arms
    step(1'b1, mk_word(4'h0, 6'h00, 3'd7, 3'd4, 1'b0, 4'd3), 1'b0, 3'd0);
    step(1'b1, mk_word(4'h0, 6'h00, 3'd0, 3'd1, 1'b0, 4'd0), 1'b0, 3'd0);
    chk("R10 blocked no issue", 32'(last_issue), 32'd0);
    step(1'b0, '0, 1'b0, 3'd0);
    chk("R10 no arm when blocked", 32'(bar_armed_o), 32'h10);
    // R5: index 6 arms nothing
    repeat (3) step(1'b0, '0, 1'b0, 3'd0);
    step(1'b1, mk_word(4'h0, 6'h00, 3'd6, 3'd6, 1'b0, 4'd0), 1'b1, 3'd4);
    step(1'b0, '0, 1'b0, 3'd0);
    chk("R5 index 6 arms nothing", 32'(bar_armed_o), 32'h00);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] st;
      logic [5:0] wm;
      int r;
      r  = int'($urandom % 8);
      st = (r < 5) ? 4'(r % 3) : ((r == 7) ? 4'd15 : 4'($urandom % 16));
      wm = ($urandom % 4 == 0) ? 6'd0 : 6'($urandom & $urandom);
      step(($urandom % 5) != 0,
           mk_word(4'($urandom), wm, 3'($urandom), 3'($urandom), 1'($urandom), st),
           ($urandom % 5) < 2, 3'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule